// File: doc/BRIEF.md
# UART Shared Scratchpad and FIFO Level Readback

This block is the register-side logic behind one UART register address that serves two purposes. In its plain form the address holds a general-purpose scratchpad byte that software can write and read back. When a swap-enable control bit is set, the address takes on a second role. Writes no longer reach the scratchpad. They load a write-only enhanced-mode register instead, and its two low bits select what a read of the address returns.

With swap enabled, the mode field picks one of four read sources: the stored scratchpad byte, the live receive FIFO fill count, the live transmit FIFO fill count, or an alternating sequence. In the alternating sequence, successive reads return the receive count and then the transmit count, and keep switching between them. Software can therefore poll both FIFO levels through a single address without rewriting the mode between polls. Fill counts range from 0 to 64 and are returned zero-extended in the read byte.

The read byte is combinational from the block's state and the live counts. Any state change caused by a strobe takes effect at the next rising clock edge.

Top module: `uart_shared_reg_readback`

## Requirements
- R1: After reset the scratchpad holds 0x00, the mode field is 00 and the alternation pointer selects the receive count, so a read returns 0x00 whether swap-enable is 0 or 1.
- R2: With swap-enable 0, a write loads all 8 bits of `wdata` into the scratchpad, and later reads with swap-enable 0 return that byte.
- R3: With swap-enable 0, reads return the scratchpad byte whatever the mode field holds.
- R4: With swap-enable 1, a write loads `wdata[1:0]` into the mode field and leaves the scratchpad unchanged.
- R5: With swap-enable 1 and mode field 00, reads return the scratchpad byte.
- R6: With swap-enable 1 and mode field 01, reads return `rx_level` zero-extended to 8 bits, for any value from 0 to 64.
- R7: With swap-enable 1 and mode field 10, reads return `tx_level` zero-extended to 8 bits.
- R8: With swap-enable 1 and mode field 11, the first read returns the receive count and the following reads alternate between transmit and receive counts.
- R9: The pointer goes back to the receive count on any write to the mode field, including a write that sets mode 11 again. It also goes back to the receive count in any cycle in which alternate mode is not in effect, either because swap-enable is 0 or because the mode field is not 11.
- R10: The alternation pointer advances only on a cycle with `rd_en` high. Cycles without a read leave the next returned count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the shared address, one cycle per access |
| rd_en | input | 1 | Read strobe for the shared address, one cycle per access |
| wdata | input | 8 | Write data |
| swap_en | input | 1 | Redirects writes to the mode register and enables the mode decode |
| rx_level | input | 7 | Receive FIFO fill count, 0 to 64 |
| tx_level | input | 7 | Transmit FIFO fill count, 0 to 64 |
| rd_data | output | 8 | Value returned for a read of the shared address |

## Verification
`rd_data` is due in the same cycle as the read strobe. It reflects state as of the previous rising edge, together with the current `swap_en` and level inputs. A write, or a read that advances the pointer, changes what is returned only from the following cycle. The bench drives inputs on the falling edge and samples `rd_data` two nanoseconds later, while the strobe is still high. It updates its reference state only after the next rising edge, so each comparison uses the state that existed before that cycle's strobe.

// File: rtl/uart_shared_reg_readback.sv
module uart_shared_reg_readback #(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              swap_en,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_level,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [1:0] SEL_SCR = 2'b00;
  localparam logic [1:0] SEL_RX  = 2'b01;
  localparam logic [1:0] SEL_TX  = 2'b10;
  localparam logic [1:0] SEL_ALT = 2'b11;
  localparam int PAD_W = DATA_W - LVL_W;

  logic [DATA_W-1:0] scratch_q;
  logic [1:0]        mode_q;
  logic              ptr_q;

  logic scr_wr, mode_wr, alt_on;
  logic [1:0] eff_sel;
  logic [DATA_W-1:0] rx_ext, tx_ext;

  assign scr_wr  = wr_en & ~swap_en;
  assign mode_wr = wr_en & swap_en;
  assign alt_on  = swap_en && (mode_q == SEL_ALT);
  assign eff_sel = swap_en ? mode_q : SEL_SCR;
  assign rx_ext  = {{PAD_W{1'b0}}, rx_level};
  assign tx_ext  = {{PAD_W{1'b0}}, tx_level};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      mode_q    <= SEL_SCR;
      ptr_q     <= 1'b0;
    end else begin
      if (scr_wr)  scratch_q <= wdata;
      if (mode_wr) mode_q    <= wdata[1:0];
      if (mode_wr || !alt_on) ptr_q <= 1'b0;
      else if (rd_en)         ptr_q <= ~ptr_q;
    end
  end

  always_comb begin
    case (eff_sel)
      SEL_RX:  rd_data = rx_ext;
      SEL_TX:  rd_data = tx_ext;
      SEL_ALT: rd_data = ptr_q ? tx_ext : rx_ext;
      default: rd_data = scratch_q;
    endcase
  end

  p_scr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !swap_en) |=> (scratch_q == $past(wdata)));

  p_mode_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !swap_en) |=> $stable(mode_q));

  p_scr_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && swap_en) |=> $stable(scratch_q));

  p_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_en && mode_q != SEL_SCR) |-> (rd_data[DATA_W-1:LVL_W] == '0));

  p_alt_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && swap_en && mode_q == SEL_ALT) |=> (ptr_q != $past(ptr_q)));

  p_ptr_home_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en && swap_en) || !(swap_en && mode_q == SEL_ALT)) |=> !ptr_q);

  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en && swap_en && mode_q == SEL_ALT) |=> $stable(ptr_q));

endmodule

// File: tb/uart_shared_reg_readback_bench.sv
module uart_shared_reg_readback_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, swap_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [6:0] rx_level = '0, tx_level = '0;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_scr;
  logic [1:0] m_mode;
  logic       m_ptr;

  always #10 clk = ~clk;

  uart_shared_reg_readback u_uart_shared_reg_readback (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .swap_en(swap_en), .rx_level(rx_level), .tx_level(tx_level), .rd_data(rd_data));

  function automatic logic [7:0] exp_read(logic sw, logic [6:0] rx, logic [6:0] tx);
    if (!sw) return m_scr;
    case (m_mode)
      2'b00: return m_scr;
      2'b01: return {1'b0, rx};
      2'b10: return {1'b0, tx};
      default: return m_ptr ? {1'b0, tx} : {1'b0, rx};
    endcase
  endfunction

  function automatic string path_tag(logic sw);
    if (!sw) return "R2/R3";
    case (m_mode)
      2'b00: return "R5";
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(logic [7:0] act, logic [7:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic wr, logic rd, logic sw, logic [7:0] wd,
                     logic [6:0] rx, logic [6:0] tx, string tag);
    logic alt_before;
    @(negedge clk);
    wr_en = wr; rd_en = rd; swap_en = sw; wdata = wd; rx_level = rx; tx_level = tx;
    #2;
    if (rd) check(rd_data, exp_read(sw, rx, tx), tag);
    alt_before = sw && (m_mode == 2'b11);
    @(posedge clk);
    #1;
    if (wr && !sw) m_scr = wd;
    if (wr && sw) m_mode = wd[1:0];
    if ((wr && sw) || !alt_before) m_ptr = 1'b0;
    else if (rd) m_ptr = ~m_ptr;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unused_seed;
    m_scr = '0; m_mode = '0; m_ptr = 1'b0;
    unused_seed = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, both swap settings
    cyc(0, 1, 0, 8'h00, 7'd12, 7'd5, "R1");
    cyc(0, 1, 1, 8'h00, 7'd12, 7'd5, "R1");
    // R2: scratchpad write and readback
    cyc(1, 0, 0, 8'hA5, 7'd0, 7'd0, "R2");
    cyc(0, 1, 0, 8'h00, 7'd3, 7'd4, "R2");
    // R4: mode write leaves scratchpad; R3: mode has no effect with swap off
    cyc(1, 0, 1, 8'hFD, 7'd0, 7'd0, "R4");
    cyc(0, 1, 0, 8'h00, 7'd9, 7'd8, "R3");
    cyc(0, 1, 0, 8'h00, 7'd9, 7'd8, "R4");
    // R6: receive count, boundaries 64 and 0
    cyc(0, 1, 1, 8'h00, 7'd64, 7'd1, "R6");
    cyc(0, 1, 1, 8'h00, 7'd0, 7'd1, "R6");
    // R7: transmit count
    cyc(1, 0, 1, 8'h02, 7'd0, 7'd0, "R4");
    cyc(0, 1, 1, 8'h00, 7'd11, 7'd37, "R7");
    cyc(0, 1, 1, 8'h00, 7'd11, 7'd64, "R7");
    // R5: mode 00 with swap on returns scratchpad
    cyc(1, 0, 1, 8'h00, 7'd0, 7'd0, "R4");
    cyc(0, 1, 1, 8'h00, 7'd50, 7'd60, "R5");
    // R8: alternation RX, TX, RX, TX
    cyc(1, 0, 1, 8'h03, 7'd0, 7'd0, "R4");
    cyc(0, 1, 1, 8'h00, 7'd21, 7'd42, "R8");
    cyc(0, 1, 1, 8'h00, 7'd21, 7'd42, "R8");
    cyc(0, 1, 1, 8'h00, 7'd21, 7'd42, "R8");
    cyc(0, 1, 1, 8'h00, 7'd21, 7'd42, "R8");
    // R10: idle cycles do not advance the pointer
    cyc(0, 1, 1, 8'h00, 7'd7, 7'd8, "R10");
    cyc(0, 0, 1, 8'h00, 7'd7, 7'd8, "R10");
    cyc(0, 0, 1, 8'h00, 7'd7, 7'd8, "R10");
    cyc(0, 1, 1, 8'h00, 7'd7, 7'd8, "R10");
    // R9: rewrite of mode 11 resets the pointer
    cyc(0, 1, 1, 8'h00, 7'd7, 7'd8, "R9");
    cyc(1, 0, 1, 8'h03, 7'd0, 7'd0, "R9");
    cyc(0, 1, 1, 8'h00, 7'd7, 7'd8, "R9");
    // R9: dropping swap for one cycle resets the pointer
    cyc(0, 0, 0, 8'h00, 7'd7, 7'd8, "R9");
    cyc(0, 1, 1, 8'h00, 7'd7, 7'd8, "R9");

    for (int i = 0; i < 4000; i++) begin
      logic wr, rd, sw;
      logic [7:0] wd;
      logic [6:0] rx, tx;
      int k;
      k  = $urandom_range(0, 9);
      wr = (k < 3);
      rd = (k >= 3 && k < 8);
      sw = ($urandom_range(0, 4) != 0);
      wd = 8'($urandom);
      if ($urandom_range(0, 1) == 1) wd[1:0] = 2'b11;
      rx = 7'($urandom_range(0, 64));
      tx = 7'($urandom_range(0, 64));
      cyc(wr, rd, sw, wd, rx, tx, path_tag(sw));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule